// File: doc/BRIEF.md
# Vacuum-Fluorescent Grid Multiplexer

This block scans a multiplexed vacuum-fluorescent display of 11 grids with 14 anodes each. It enables one grid at a time in ascending order and presents that grid's anode pattern from an on-chip image store of 11 rows by 14 bits. A segment glows only while both its anode enable and the enable of the grid above it are high. Both output groups are active high and feed the high-voltage drivers outside the block.

Every grid slot runs break-before-make. The previous grid is dropped first. The anodes for the coming grid are latched one cycle later, during a blank gap with all grids dark, and only after that gap is the new grid raised. This keeps one grid's segments from ghosting onto its neighbour. Slot and active times come from the clock frequency parameter: a 488 µs slot, made of 61 µs dark and 427 µs lit, gives a 5.368 ms frame.

A host writes image rows through a simple address/data port. A new row appears only when its grid's slot next begins. During reset the store is filled with one of four images. Two active-low straps choose it, and leaving the straps at their default lights every segment.

Top module: `vfd_mux`

## Requirements
- R1: While reset is held and on the first cycle after its release, all grid and anode outputs are low.
- R2: At most one grid output is high in any cycle.
- R3: Grids light in the order 0, 1, … 10 and then wrap to 0; the first grid lit after reset is grid 0.
- R4: Each grid stays high for exactly 427 consecutive cycles at the default 1 MHz clock.
- R5: Between one grid falling and the next rising, all grids are low for exactly 61 cycles. The anode outputs do not change in the cycle the grid falls, and they never change while any grid is high.
- R6: While grid g is high, the anode outputs equal image row g.
- R7: With the straps at dtestN=1 and lteN=1 at reset, every row is 14'h0000 (all segments dark).
- R8: With dtestN=1 and lteN=0 at reset, every row is 14'h3FFF (all segments lit; this is the default strap state).
- R9: With dtestN=0 and lteN=1 at reset, even rows are 14'h1555 and odd rows are 14'h2AAA (checkerboard).
- R10: With dtestN=0 and lteN=0 at reset, even rows are 14'h2AAA and odd rows are 14'h1555 (inverse checkerboard).
- R11: A row write (wrEn high at a clock edge, row wrAddr, value wrData) never alters the anodes of a strobe in progress. It is shown from the next slot of that row's grid, which includes the very next slot if that slot belongs to the row.
- R12: A write with wrAddr of 11 or above changes no row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_HZ |
| rstN | input | 1 | Synchronous active-low reset; loads the strap-selected image |
| dtestN | input | 1 | Active-low test-image strap, sampled during reset |
| lteN | input | 1 | Active-low image-select strap, sampled during reset |
| wrEn | input | 1 | Row write strobe |
| wrAddr | input | 4 | Row to write, 0 to 10 |
| wrData | input | 14 | Anode pattern for the row |
| gridOut | output | 11 | Grid enables, one-hot or zero, active high |
| anodeOut | output | 14 | Anode enables for the lit grid, active high |

## Verification
A slot counter or grid index that goes astray shows at the grid pins within a single slot, at most 488 cycles. The symptom is a lit time other than 427, a dark gap other than 61, or the wrong grid rising after the gap. A corrupted image row or a misrouted write shows on the anode pins the next time that row's grid rises, at most one frame of 5368 cycles later. A load that fires at the wrong phase shows as anodes moving while a grid is high or in the same cycle the grid drops. The bench measures every lit period and every gap cycle by cycle across whole frames for each strap setting.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  // Strobes from the slot sequencer to the datapath
  typedef struct packed {
    logic gridEn;   // selected grid may be lit this cycle
    logic loadRow;  // latch the selected row onto the anodes
  } strobe_t;

  // Power-up image chosen by the straps
  typedef enum logic [1:0] {
    IMG_DARK  = 2'd0,
    IMG_LIT   = 2'd1,
    IMG_CHK_A = 2'd2,
    IMG_CHK_B = 2'd3
  } image_e;

  function automatic image_e decodeStraps(input logic dtestN, input logic lteN);
    image_e img;
    case ({dtestN, lteN})
      2'b11:   img = IMG_DARK;
      2'b10:   img = IMG_LIT;
      2'b01:   img = IMG_CHK_A;
      default: img = IMG_CHK_B;
    endcase
    return img;
  endfunction

endpackage

// File: rtl/vfd_ctrl.sv
module vfd_ctrl
  import vfd_pkg::*;
#(
  parameter int SLOT_CYC  = 488,
  parameter int BLANK_CYC = 61,
  parameter int GRIDS     = 11,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  output strobe_t          strobe,
  output logic [IDX_W-1:0] gridIdx
);

  localparam int CNT_W   = $clog2(SLOT_CYC);
  localparam int LOAD_AT = 1;  // one cycle after the grid has dropped

  logic [CNT_W-1:0] slotCnt;
  logic             slotEnd;

  assign slotEnd = (slotCnt == CNT_W'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= '0;
      gridIdx <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      gridIdx <= (gridIdx == IDX_W'(GRIDS - 1)) ? '0 : gridIdx + 1'b1;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.gridEn  = (slotCnt >= CNT_W'(BLANK_CYC));
    strobe.loadRow = (slotCnt == CNT_W'(LOAD_AT));
  end

  // R4: slot counter stays inside its slot
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rstN)
    slotCnt < CNT_W'(SLOT_CYC));

  // R3: grid index stays within the display
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    gridIdx < IDX_W'(GRIDS));

  // R3: after the last grid's slot the scan restarts at grid 0
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (slotEnd && gridIdx == IDX_W'(GRIDS - 1)) |=> (gridIdx == '0));

  // R3: the index holds steady through a slot
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!slotEnd) |=> $stable(gridIdx));

endmodule

// File: rtl/vfd_dpath.sv
module vfd_dpath
  import vfd_pkg::*;
#(
  parameter int GRIDS  = 11,
  parameter int ANODES = 14,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dtestN,
  input  logic              lteN,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  gridIdx,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [ANODES-1:0] wrData,
  output logic [GRIDS-1:0]  gridOut,
  output logic [ANODES-1:0] anodeOut
);

  // Checkerboard: even phase sets even bit positions
  function automatic logic [ANODES-1:0] chkMask(input logic oddPhase);
    logic [ANODES-1:0] m;
    for (int b = 0; b < ANODES; b++) m[b] = ((b % 2) == 1) == oddPhase;
    return m;
  endfunction

  function automatic logic [ANODES-1:0] imageRow(input image_e img, input int row);
    logic [ANODES-1:0] v;
    case (img)
      IMG_DARK:  v = '0;
      IMG_LIT:   v = '1;
      IMG_CHK_A: v = chkMask((row % 2) == 1);
      default:   v = ~chkMask((row % 2) == 1);
    endcase
    return v;
  endfunction

  image_e            bootImg;
  logic [ANODES-1:0] rowMem [GRIDS];
  logic [ANODES-1:0] rowSel;
  logic [GRIDS-1:0]  gridHot;

  assign bootImg = decodeStraps(dtestN, lteN);

  for (genvar r = 0; r < GRIDS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN)
        rowMem[r] <= imageRow(bootImg, r);
      else if (wrEn && wrAddr == IDX_W'(r))
        rowMem[r] <= wrData;
    end

    // R12: a write aimed beyond the display leaves every row untouched
    a_r12_no_alias: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr >= IDX_W'(GRIDS)) |=> $stable(rowMem[r]));
  end

  always_comb begin
    rowSel  = '0;
    gridHot = '0;
    for (int r = 0; r < GRIDS; r++) begin
      if (gridIdx == IDX_W'(r)) begin
        rowSel     = rowMem[r];
        gridHot[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gridOut  <= '0;
      anodeOut <= '0;
    end else begin
      gridOut <= strobe.gridEn ? gridHot : '0;
      if (strobe.loadRow) anodeOut <= rowSel;
    end
  end

  // R2: never two grids at once
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gridOut));

  // R5: a lit grid is only ever followed by itself or by darkness
  a_r5_break_first: assert property (@(posedge clk) disable iff (!rstN)
    ((|$past(gridOut)) && gridOut != $past(gridOut)) |-> (gridOut == '0));

  // R5/R11: anodes move only after a full dark cycle
  a_r5_load_dark: assert property (@(posedge clk) disable iff (!rstN)
    (anodeOut != $past(anodeOut)) |-> (gridOut == '0 && $past(gridOut) == '0));

  // R11: anodes frozen while a grid is lit
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (|gridOut) |-> $stable(anodeOut));

endmodule

// File: rtl/vfd_mux.sv
module vfd_mux
  import vfd_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int GRIDS     = 11,
  parameter int ANODES    = 14,
  parameter int ACTIVE_US = 427,
  parameter int SLOT_US   = 488,
  localparam int IDX_W    = $clog2(GRIDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dtestN,
  input  logic              lteN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [ANODES-1:0] wrData,
  output logic [GRIDS-1:0]  gridOut,
  output logic [ANODES-1:0] anodeOut
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SLOT_CYC   = SLOT_US * CYC_PER_US;
  localparam int ACTIVE_CYC = ACTIVE_US * CYC_PER_US;
  localparam int BLANK_CYC  = SLOT_CYC - ACTIVE_CYC;

  strobe_t          strobe;
  logic [IDX_W-1:0] gridIdx;

  vfd_ctrl #(
    .SLOT_CYC (SLOT_CYC),
    .BLANK_CYC(BLANK_CYC),
    .GRIDS    (GRIDS),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .gridIdx(gridIdx)
  );

  vfd_dpath #(
    .GRIDS (GRIDS),
    .ANODES(ANODES),
    .IDX_W (IDX_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .dtestN  (dtestN),
    .lteN    (lteN),
    .strobe  (strobe),
    .gridIdx (gridIdx),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .gridOut (gridOut),
    .anodeOut(anodeOut)
  );

  // R1: outputs dark on the first cycle out of reset
  a_r1_dark_start: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(rstN)) |-> (gridOut == '0 && anodeOut == '0));

endmodule

// File: tb/sim_vfd_mux.sv
module sim_vfd_mux;

  localparam time CLK_PERIOD = 10ns;
  localparam int  LIT_CYC    = 427;
  localparam int  GAP_CYC    = 61;

  typedef struct packed {
    logic        dtestN;
    logic        lteN;
    logic [13:0] evenRow;
    logic [13:0] oddRow;
  } vec_t;

  // strap setting and the image it must produce
  localparam vec_t VECS [4] = '{
    '{1'b1, 1'b1, 14'h0000, 14'h0000},  // R7 all dark
    '{1'b1, 1'b0, 14'h3FFF, 14'h3FFF},  // R8 all lit
    '{1'b0, 1'b1, 14'h1555, 14'h2AAA},  // R9 checkerboard
    '{1'b0, 1'b0, 14'h2AAA, 14'h1555}   // R10 inverse checkerboard
  };
  localparam string VEC_TAG [4] = '{"R7", "R8", "R9", "R10"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dtestN = 1'b1;
  logic        lteN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [13:0] wrData = '0;
  logic [10:0] gridOut;
  logic [13:0] anodeOut;

  int checks = 0;
  int errors = 0;
  logic [13:0] expRow [11];
  logic [13:0] lastAnode;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vfd_mux u0 (
    .clk     (clk),
    .rstN    (rstN),
    .dtestN  (dtestN),
    .lteN    (lteN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .gridOut (gridOut),
    .anodeOut(anodeOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL R4 watchdog expired: actual 1 expected 0");
    finishRun();
  end

  // reset with given straps; returns at the first sample after release
  task automatic doReset(input logic dt, input logic lt);
    @(negedge clk);
    rstN   = 1'b0;
    dtestN = dt;
    lteN   = lt;
    wrEn   = 1'b0;
    repeat (3) @(negedge clk);
    check(gridOut == '0, "R1", "grids in reset", gridOut, 0);
    check(anodeOut == '0, "R1", "anodes in reset", anodeOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(gridOut == '0 && anodeOut == '0, "R1", "outputs after release",
          {gridOut, anodeOut}, 0);
    lastAnode = '0;
  endtask

  // Called at the first dark sample of a gap; measures gap and lit period of grid g,
  // optionally writing a row in mid strobe. Returns at the next first dark sample.
  task automatic runSlot(input int g, input string tag, input bit doWr,
                         input logic [3:0] wa, input logic [13:0] wd);
    int low = 0;
    int high = 0;
    bit steady = 1'b1;
    logic [13:0] expA;
    expA = expRow[g];
    check(anodeOut == lastAnode, "R5", "anodes at grid drop", anodeOut, lastAnode);
    while (gridOut == '0 && low < 2000) begin
      low++;
      @(negedge clk);
    end
    check(low == GAP_CYC, "R5", "dark gap length", low, GAP_CYC);
    check(gridOut == (11'd1 << g), "R3", "grid order", gridOut, 11'd1 << g);
    check(anodeOut == expA, tag, "row on anodes", anodeOut, expA);
    while (gridOut != '0 && high < 2000) begin
      if (anodeOut != expA) steady = 1'b0;
      if (doWr && high == 100) begin
        wrEn   = 1'b1;
        wrAddr = wa;
        wrData = wd;
      end else begin
        wrEn = 1'b0;
      end
      high++;
      @(negedge clk);
    end
    wrEn = 1'b0;
    check(high == LIT_CYC, "R4", "lit length", high, LIT_CYC);
    check(steady, "R11", "anodes steady while lit", steady, 1);
    lastAnode = expA;
    if (doWr && wa < 4'd11) expRow[wa] = wd;
  endtask

  task automatic runSpan(input int first, input int count, input string tag);
    for (int k = 0; k < count; k++) runSlot((first + k) % 11, tag, 1'b0, '0, '0);
  endtask

  initial begin
    // table: each strap setting, one full frame plus the wrap to grid 0
    for (int v = 0; v < 4; v++) begin
      for (int r = 0; r < 11; r++)
        expRow[r] = (r % 2 == 0) ? VECS[v].evenRow : VECS[v].oddRow;
      doReset(VECS[v].dtestN, VECS[v].lteN);
      runSpan(0, 12, VEC_TAG[v]);  // R6 rows match image, R3 wrap
    end

    // R11: writes during strobes, starting from the dark image
    for (int r = 0; r < 11; r++) expRow[r] = 14'h0000;
    doReset(1'b1, 1'b1);
    runSpan(0, 5, "R6");
    runSlot(5, "R6", 1'b1, 4'd6, 14'h2468);   // row 6 written while grid 5 lit
    runSlot(6, "R11", 1'b0, '0, '0);          // shown in the very next slot
    runSpan(7, 7, "R6");                      // grids 7..10, 0..2
    runSlot(3, "R6", 1'b1, 4'd3, 14'h1234);   // own row written mid strobe
    runSpan(4, 10, "R6");                     // grids 4..10, 0..2
    runSlot(3, "R11", 1'b0, '0, '0);          // new value one frame later

    // R12: writes beyond the last row change nothing
    runSlot(4, "R6", 1'b1, 4'd11, 14'h3FFF);
    runSlot(5, "R6", 1'b1, 4'd15, 14'h3FFF);
    runSpan(6, 11, "R12");                    // full frame, image unchanged

    // R8: default strap state gives all segments lit
    for (int r = 0; r < 11; r++) expRow[r] = 14'h3FFF;
    doReset(1'b1, 1'b0);
    runSpan(0, 2, "R8");

    finishRun();
  end

endmodule